// File: doc/BRIEF.md
# Interrupt Source Controller

This block holds a parameterised array of interrupt sources, 16 by default, and hands them one at a time to a downstream presentation controller. Each source is either level-sensitive or message-type. The type is fixed per source by the `LEVEL_MASK` parameter: bit i set makes source i level-sensitive. Each source holds a target server and an 8-bit priority. A priority of 0xFF means the source is masked. Internally each source tracks four status bits: asserted, sent, rejected and masked-pending. It also tracks whether an offer for it is waiting.

An offer carries the server, the priority and a global source number, which is the local index plus the parameter `BASE`. The downstream controller can send back three strobes. A reject tells the block that an offer was displaced. An end-of-interrupt marks an offer as handled. A resend asks the block to re-evaluate every source. Reject and end-of-interrupt carry a global number; the block subtracts `BASE` from it and ignores numbers that fall outside its own range. A configuration port writes the server and priority of one source.

Top module: `irq_source_ctl`

## Requirements
- R1: After reset no offer is presented, every priority is 0xFF and every status bit is clear. Each source keeps its type.
- R2: A message source signalled while its priority is not 0xFF is offered with number `BASE`+index, its priority and its server.
- R3: A message source signalled while its priority is 0xFF is not offered and becomes masked-pending. A later configuration write with a priority other than 0xFF clears masked-pending and offers the source.
- R4: A reject of a message source sets rejected. A resend clears rejected and re-offers the source if it is unmasked. An end-of-interrupt of a message source has no effect.
- R5: A level source is offered when its priority is not 0xFF, its input is high and sent is clear. Offering it sets sent, and it is not offered again while sent stays set.
- R6: A reject or end-of-interrupt of a level source clears sent without offering it. The source is re-evaluated against the R5 rule on a resend, on a change of its input level, or on a configuration write.
- R7: Reject and end-of-interrupt numbers have `BASE` subtracted. A number below `BASE` or at or above `BASE`+`NSRC` is ignored.
- R8: An offer stays presented until `offer_ready` is high in a cycle with `offer_valid` high. At most one offer is taken per cycle.
- R9: When several offers wait, the one chosen is the lowest waiting index at or after a round-robin pointer, wrapping past the top index. After an accept, the pointer moves to the accepted index plus one.
- R10: A configuration write of priority 0xFF to a source with a waiting offer withdraws that offer. A message source becomes masked-pending; a level source has sent cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NSRC | Level input (level sources) or one-cycle message strobe (message sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority, 0xFF masks |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | Downstream takes the offer |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |
| offer_server | output | SRV_W | Target server of the offer |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number completed |
| resend | input | 1 | Re-evaluate all sources |

## Verification
A vector table drives single message sources with different indices, servers and priorities, including priority 0 and 0xFE. Each vector checks the number-offset arithmetic and the payload, then checks that a stalled handshake keeps the offer. Directed sequences then separate the two source types. The same reject, end-of-interrupt and resend strobes are applied to a message source and to a level source, and the outcomes differ: re-offer, no effect, or a cleared sent bit. Out-of-range numbers, masking writes to a waiting source, and three simultaneous strobes check that the round-robin order differs from a plain lowest-index order.

// File: rtl/irq_source_ctl.sv
module irq_source_ctl #(
  parameter int NSRC = 16,
  parameter int PRIO_W = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 16,
  parameter int BASE = 4096,
  parameter logic [NSRC-1:0] LEVEL_MASK = 16'hFF00,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  output logic              offer_valid,
  input  logic              offer_ready,
  output logic [NUM_W-1:0]  offer_num,
  output logic [PRIO_W-1:0] offer_prio,
  output logic [SRV_W-1:0]  offer_server,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [SRV_W-1:0]  srv_q  [NSRC];
  logic [NSRC-1:0] asrt_q, sent_q, rej_q, mpend_q, wait_q;
  logic [NSRC-1:0] asrt_d, sent_d, rej_d, mpend_d, wait_d;
  logic [IDX_W-1:0] rr_q, sel;

  logic [NUM_W-1:0] rej_loc, eoi_loc;
  logic rej_hit, eoi_hit, pop;

  assign rej_loc = rej_num - NUM_W'(BASE);
  assign eoi_loc = eoi_num - NUM_W'(BASE);
  assign rej_hit = rej_valid && (rej_num >= NUM_W'(BASE)) && (rej_loc < NUM_W'(NSRC));
  assign eoi_hit = eoi_valid && (eoi_num >= NUM_W'(BASE)) && (eoi_loc < NUM_W'(NSRC));

  assign offer_valid  = |wait_q;
  assign offer_num    = NUM_W'(BASE) + NUM_W'(sel);
  assign offer_prio   = prio_q[sel];
  assign offer_server = srv_q[sel];
  assign pop          = offer_valid && offer_ready;

  always_comb begin
    logic found;
    found = 1'b0;
    sel = '0;
    for (int k = 0; k < NSRC; k++) begin
      int j;
      j = (int'(rr_q) + k) % NSRC;
      if (!found && wait_q[j]) begin
        found = 1'b1;
        sel = IDX_W'(j);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      logic cfg_hit, mine_rej, mine_eoi, eval;
      logic [PRIO_W-1:0] np;
      cfg_hit  = cfg_we && (cfg_idx == IDX_W'(i));
      mine_rej = rej_hit && (rej_loc == NUM_W'(i));
      mine_eoi = eoi_hit && (eoi_loc == NUM_W'(i));
      np = cfg_hit ? cfg_prio : prio_q[i];
      asrt_d[i]  = irq_i[i];
      sent_d[i]  = sent_q[i];
      rej_d[i]   = rej_q[i];
      mpend_d[i] = mpend_q[i];
      wait_d[i]  = wait_q[i] & ~(pop && (sel == IDX_W'(i)));
      if (LEVEL_MASK[i]) begin
        if (mine_rej || mine_eoi) sent_d[i] = 1'b0;
        if (cfg_hit && np == MASKED && wait_d[i]) begin
          wait_d[i] = 1'b0;
          sent_d[i] = 1'b0;
        end
        eval = (irq_i[i] != asrt_q[i]) || resend || cfg_hit;
        if (eval && np != MASKED && irq_i[i] && !sent_d[i]) begin
          sent_d[i] = 1'b1;
          wait_d[i] = 1'b1;
        end
      end else begin
        if (mine_rej) rej_d[i] = 1'b1;
        if (irq_i[i]) begin
          if (prio_q[i] == MASKED) mpend_d[i] = 1'b1;
          else wait_d[i] = 1'b1;
        end
        if (cfg_hit) begin
          if (np == MASKED) begin
            if (wait_d[i]) begin
              wait_d[i] = 1'b0;
              mpend_d[i] = 1'b1;
            end
          end else if (mpend_d[i]) begin
            mpend_d[i] = 1'b0;
            wait_d[i] = 1'b1;
          end
        end
        if (resend && rej_d[i]) begin
          rej_d[i] = 1'b0;
          if (np != MASKED) wait_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asrt_q <= '0;
      sent_q <= '0;
      rej_q <= '0;
      mpend_q <= '0;
      wait_q <= '0;
      rr_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= MASKED;
        srv_q[i] <= '0;
      end
    end else begin
      asrt_q <= asrt_d;
      sent_q <= sent_d;
      rej_q <= rej_d;
      mpend_q <= mpend_d;
      wait_q <= wait_d;
      if (pop) rr_q <= (int'(sel) == NSRC - 1) ? '0 : sel + 1'b1;
      if (cfg_we) begin
        prio_q[cfg_idx] <= cfg_prio;
        srv_q[cfg_idx] <= cfg_server;
      end
    end
  end
endmodule

// File: rtl/irq_source_ctl_chk.sv
module irq_source_ctl_chk #(
  parameter int NSRC = 16,
  parameter int PRIO_W = 8,
  parameter int NUM_W = 16,
  parameter int BASE = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              offer_valid,
  input logic              offer_ready,
  input logic [NUM_W-1:0]  offer_num,
  input logic [PRIO_W-1:0] offer_prio
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !offer_valid);

  assert_num_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_num >= NUM_W'(BASE)) && (offer_num < NUM_W'(BASE + NSRC)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready && !cfg_we |=> offer_valid);

  assert_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> offer_prio != '1);
endmodule

bind irq_source_ctl irq_source_ctl_chk #(
  .NSRC(NSRC), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .offer_valid(offer_valid),
  .offer_ready(offer_ready), .offer_num(offer_num), .offer_prio(offer_prio)
);

// File: tb/irq_source_ctl_bench.sv
module irq_source_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] irq_i = '0;
  logic cfg_we = 0;
  logic [3:0] cfg_idx = '0, cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic offer_valid, offer_ready = 0;
  logic [15:0] offer_num;
  logic [7:0] offer_prio;
  logic [3:0] offer_server;
  logic rej_valid = 0, eoi_valid = 0, resend = 0;
  logic [15:0] rej_num = '0, eoi_num = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  // index[15:12] server[11:8] priority[7:0]
  localparam logic [15:0] VEC [0:3] = '{16'h0110, 16'h3200, 16'h7FFE, 16'h5080};

  irq_source_ctl u_irq_source_ctl (.*);

  always #10 clk = ~clk;

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] idx, input logic [3:0] srv, input logic [7:0] p);
    cfg_we = 1; cfg_idx = idx; cfg_server = srv; cfg_prio = p;
    cyc(); cfg_we = 0;
  endtask

  task automatic pulse(input logic [15:0] m);
    irq_i = irq_i | m; cyc(); irq_i = irq_i & ~m;
  endtask

  task automatic accept();
    offer_ready = 1; cyc(); offer_ready = 0;
  endtask

  task automatic reject(input logic [15:0] n);
    rej_valid = 1; rej_num = n; cyc(); rej_valid = 0;
  endtask

  task automatic eoi(input logic [15:0] n);
    eoi_valid = 1; eoi_num = n; cyc(); eoi_valid = 0;
  endtask

  task automatic do_resend();
    resend = 1; cyc(); resend = 0;
  endtask

  task automatic chk(input string req, input logic [15:0] n, input logic [7:0] p, input logic [3:0] s);
    checks++;
    if (!offer_valid || offer_num !== n || offer_prio !== p || offer_server !== s) begin
      failures++;
      $display("FAIL %s: got v=%b num=%0d prio=%h srv=%0d, expected v=1 num=%0d prio=%h srv=%0d",
               req, offer_valid, offer_num, offer_prio, offer_server, n, p, s);
    end
  endtask

  task automatic chk_none(input string req);
    checks++;
    if (offer_valid !== 1'b0) begin
      failures++;
      $display("FAIL %s: got offer_valid=%b num=%0d, expected offer_valid=0", req, offer_valid, offer_num);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_none("R1 idle after reset");
    cyc();
    pulse(16'h0004);
    chk_none("R1 priority masked after reset");
    cfg(4'd2, 4'd6, 8'h20);
    chk("R3 masked-pending released", 16'd4098, 8'h20, 4'd6);
    accept();
    chk_none("R8 offer removed after accept");

    for (int v = 0; v < 4; v++) begin
      logic [3:0] idx, srv;
      logic [7:0] p;
      {idx, srv, p} = VEC[v];
      cfg(idx, srv, p);
      pulse(16'h1 << idx);
      chk("R2 message offer", 16'd4096 + 16'(idx), p, srv);
      repeat (3) cyc();
      chk("R8 offer held while stalled", 16'd4096 + 16'(idx), p, srv);
      accept();
      chk_none("R8 single accept");
    end

    cfg(4'd1, 4'd4, 8'h30);
    pulse(16'h0002);
    chk("R2 source 1", 16'd4097, 8'h30, 4'd4);
    accept();
    reject(16'd4097);
    chk_none("R4 reject no re-offer");
    do_resend();
    chk("R4 resend re-offers rejected", 16'd4097, 8'h30, 4'd4);
    accept();
    do_resend();
    chk_none("R4 rejected cleared by resend");
    eoi(16'd4097);
    do_resend();
    chk_none("R4 eoi no effect on message");

    cfg(4'd8, 4'd3, 8'h40);
    chk_none("R5 level low not offered");
    irq_i[8] = 1; cyc();
    chk("R5 level offer", 16'd4104, 8'h40, 4'd3);
    accept();
    cyc();
    chk_none("R5 no repeat while sent");
    eoi(16'd8);
    do_resend();
    chk_none("R7 eoi below base ignored");
    reject(16'd4112);
    do_resend();
    chk_none("R7 reject above range ignored");
    eoi(16'd4104);
    chk_none("R6 eoi clears sent without offer");
    do_resend();
    chk("R6 resend re-evaluates level", 16'd4104, 8'h40, 4'd3);
    accept();
    reject(16'd4104);
    chk_none("R6 reject no offer");
    irq_i[8] = 0; cyc();
    irq_i[8] = 1; cyc();
    chk("R6 level change re-evaluates", 16'd4104, 8'h40, 4'd3);
    accept();
    irq_i[8] = 0; cyc();

    irq_i[9] = 1; cyc();
    chk_none("R5 masked level not offered");
    cfg(4'd9, 4'd1, 8'h50);
    chk("R6 config write re-evaluates", 16'd4105, 8'h50, 4'd1);
    accept();
    irq_i[9] = 0; cyc();

    pulse(16'h0008);
    chk("R2 source 3", 16'd4099, 8'h00, 4'd2);
    cfg(4'd3, 4'd2, 8'hFF);
    chk_none("R10 masking write withdraws offer");
    cfg(4'd3, 4'd2, 8'h05);
    chk("R10 withdrawn offer became masked-pending", 16'd4099, 8'h05, 4'd2);
    accept();

    pulse(16'h0007);
    chk("R9 wrap to lowest", 16'd4096, 8'h10, 4'd1);
    accept();
    pulse(16'h0001);
    chk("R9 pointer past accepted index", 16'd4097, 8'h30, 4'd4);
    accept();
    chk("R9 next in order", 16'd4098, 8'h20, 4'd6);
    accept();
    chk("R9 wrap back", 16'd4096, 8'h10, 4'd1);
    accept();
    chk_none("R9 all drained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule